// File: doc/BRIEF.md
# Four-Channel DMA Register Bank

This block holds the programming registers of four DMA channels and sits on a simple CPU register bus. Each channel owns a twelve-byte group with a source address, a destination address, a 16-bit transfer count and a 16-bit control halfword. The CPU may access any of them with byte, halfword or word accesses. Narrow writes merge into the stored value, leaving the rest of the register as it was. Reads apply fixed masks: the address and count registers are write-only, and the control halfword is filtered by a mask that depends on the channel.

The stored values drive each channel's transfer engine continuously. A one-cycle enable-rise strobe tells an engine that software has just armed it, so the engine can latch its working copies. The block does not move data, arbitrate between channels or raise interrupts.

Control halfword layout, as seen by the engines: bits 6:5 destination step mode, bits 8:7 source step mode, bit 9 repeat, bit 10 word-sized transfer, bits 13:11 start trigger, bit 14 interrupt on completion, bit 15 channel enable.

Top module: `dma_regbank`

## Requirements
- R1: Channel i (0..3) occupies byte offsets 0xB0+12*i to 0xB0+12*i+11. Within a group, the source address is at +0, the destination at +4, the 16-bit count at +8 and the 16-bit control at +10, all little-endian. An access to any offset outside 0xB0..0xDF reads zero and changes nothing.
- R2: bus_size encodes 0 = byte, 1 = halfword, 2 = word. Write data is taken from the low bits of bus_wdata. Read data is returned in the low bits of bus_rdata, and all unused upper bits are zero. bus_rdata is zero when no read is requested.
- R3: An access with bus_size 3, a halfword at an odd offset, or a word at an offset that is not a multiple of 4 reads zero and changes nothing.
- R4: After every write, the stored source and destination addresses equal the merged value ANDed with 0x0FFFFFFE.
- R5: A byte or halfword write replaces only the addressed bytes of the stored register. Every other bit keeps its value.
- R6: A word write at +8 loads bits 15:0 into the count and bits 31:16 into the control.
- R7: Reads of the source, destination and count locations return zero at every width.
- R8: The control halfword reads back ANDed with 0xFFE0 for channel 3 and with 0xF7E0 for channels 0 to 2. The ctrl_word output always carries the unmasked stored value.
- R9: enable_rise[i] is high for exactly one cycle, in the cycle after a write to channel i that changes control bit 15 from 0 to 1. Such a write may be a byte, halfword or word write. A write that leaves bit 15 at 1, or clears it, gives no strobe.
- R10: After a synchronous active-low reset, all stored registers are zero and no strobe is high.
- R11: A write becomes visible on the register outputs at the clock edge that accepts it. Without a write, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data, low-aligned |
| bus_rdata | output | 32 | Read data, low-aligned, combinational |
| src_addr | output | 128 | Stored source address, 32 bits per channel |
| dst_addr | output | 128 | Stored destination address, 32 bits per channel |
| xfer_count | output | 64 | Stored count, 16 bits per channel |
| ctrl_word | output | 64 | Stored control, 16 bits per channel |
| enable_rise | output | 4 | One-cycle arm strobe per channel |

## Verification
The assertions assume that bus_valid, bus_write, bus_size and bus_addr hold known values at every clock edge after reset. They also assume that the write strobe and the read path see the same request within one cycle. The stimulus changes every input only on the falling edge and keeps all of them defined from time zero. Illegal sizes, misaligned offsets and offsets outside the window are driven on purpose, so the assertions on zero readback and on held state are exercised with requests that the decoder must reject.

// File: rtl/dma_regbank_pkg.sv
// Shared encodings and lane helpers for the DMA register bank.
// Assumes little-endian byte lanes and low-aligned bus data.
package dma_regbank_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    localparam logic [31:0] ADDR_KEEP = 32'h0FFF_FFFE;

    // True when the size code is legal and the offset is naturally aligned.
    function automatic logic size_ok(input logic [1:0] sz, input logic [1:0] boff);
        case (sz)
            SZ_BYTE: size_ok = 1'b1;
            SZ_HALF: size_ok = (boff[0] == 1'b0);
            SZ_WORD: size_ok = (boff == 2'd0);
            default: size_ok = 1'b0;
        endcase
    endfunction

    // Replace the addressed lane(s) of a 32-bit word with low-aligned write data.
    function automatic logic [31:0] lane_merge(input logic [31:0] old, input logic [31:0] wdata,
                                               input logic [1:0] sz, input logic [1:0] boff);
        logic [31:0] r;
        r = old;
        case (sz)
            SZ_BYTE: r[8*boff +: 8]     = wdata[7:0];
            SZ_HALF: r[16*boff[1] +: 16] = wdata[15:0];
            SZ_WORD: r                   = wdata;
            default: r                   = old;
        endcase
        return r;
    endfunction

    // Pull the addressed lane(s) out of a 32-bit word, low-aligned, upper bits zero.
    function automatic logic [31:0] lane_extract(input logic [31:0] view,
                                                 input logic [1:0] sz, input logic [1:0] boff);
        case (sz)
            SZ_BYTE: lane_extract = {24'h0, view[8*boff +: 8]};
            SZ_HALF: lane_extract = {16'h0, view[16*boff[1] +: 16]};
            SZ_WORD: lane_extract = view;
            default: lane_extract = 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_decode.sv
// Address decoder: finds which channel group an offset falls into and splits
// the offset inside the group into a word index and a byte lane.
// Assumes group bases are multiples of 4 and STRIDE is at most 16.
module dma_addr_decode #(
    parameter int NCH    = 4,
    parameter int AW     = 8,
    parameter int BASE   = 'hB0,
    parameter int STRIDE = 12
) (
    input  logic [AW-1:0]  addr,
    output logic [NCH-1:0] hit,
    output logic [1:0]     word_sel,
    output logic [1:0]     boff
);
    logic [AW-1:0] rel [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_win
        localparam int LO = BASE + STRIDE * i;
        // Window compare and offset relative to this channel's group base.
        assign hit[i] = (int'(addr) >= LO) && (int'(addr) < LO + STRIDE);
        assign rel[i] = addr - AW'(LO);
    end

    // Select the relative offset of the channel that matched.
    always_comb begin
        word_sel = 2'd0;
        boff     = 2'd0;
        for (int i = 0; i < NCH; i++) begin
            if (hit[i]) begin
                word_sel = rel[i][3:2];
                boff     = rel[i][1:0];
            end
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
// Storage for one channel: source, destination, count and control, with
// lane-merging writes, address masking and the enable-rise strobe.
// Assumes wr_hit is already qualified by decode, direction and alignment.
module dma_chan_regs
    import dma_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic [1:0]  word_sel,
    input  logic [1:0]  boff,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    output logic [31:0] src,
    output logic [31:0] dst,
    output logic [15:0] count,
    output logic [15:0] ctrl,
    output logic        enable_rise
);
    logic [31:0] src_n, dst_n, cc_n;

    // Next-state values for a write landing on this channel.
    always_comb begin
        src_n = src;
        dst_n = dst;
        cc_n  = {ctrl, count};
        case (word_sel)
            2'd0:    src_n = lane_merge(src, wdata, size, boff) & ADDR_KEEP;
            2'd1:    dst_n = lane_merge(dst, wdata, size, boff) & ADDR_KEEP;
            2'd2:    cc_n  = lane_merge({ctrl, count}, wdata, size, boff);
            default: cc_n  = {ctrl, count};
        endcase
    end

    // Register update and one-cycle strobe on a 0->1 enable transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src         <= '0;
            dst         <= '0;
            count       <= '0;
            ctrl        <= '0;
            enable_rise <= 1'b0;
        end else if (wr_hit) begin
            src         <= src_n;
            dst         <= dst_n;
            count       <= cc_n[15:0];
            ctrl        <= cc_n[31:16];
            enable_rise <= !ctrl[15] && cc_n[31];
        end else begin
            enable_rise <= 1'b0;
        end
    end

    // R9: a strobe means enable is now set and was clear before the write.
    a_r9_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
        enable_rise |-> (ctrl[15] && !$past(ctrl[15])));
    // R9: the strobe never lasts two cycles.
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        enable_rise |=> !enable_rise);
    // R11: without a write the stored state holds.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable({src, dst, count, ctrl}));
endmodule

// File: rtl/dma_read_mux.sv
// Read path: builds the masked word view of the addressed location and
// extracts the requested lanes. Only the control halfword is readable.
// Assumes at most one bit of hit is set.
module dma_read_mux
    import dma_regbank_pkg::*;
#(
    parameter int          NCH       = 4,
    parameter int          FULL_CH   = 3,
    parameter logic [15:0] MASK_STD  = 16'hF7E0,
    parameter logic [15:0] MASK_FULL = 16'hFFE0
) (
    input  logic              rd_en,
    input  logic [NCH-1:0]    hit,
    input  logic [1:0]        word_sel,
    input  logic [1:0]        boff,
    input  logic [1:0]        size,
    input  logic [NCH*16-1:0] ctrl_flat,
    output logic [31:0]       rdata
);
    logic [31:0] ch_view [NCH];
    logic [31:0] view;

    for (genvar i = 0; i < NCH; i++) begin : g_view
        localparam logic [15:0] MASK = (i == FULL_CH) ? MASK_FULL : MASK_STD;
        // Masked control in the upper half of the count/control word; others read zero.
        assign ch_view[i] = (hit[i] && word_sel == 2'd2)
                          ? {ctrl_flat[i*16 +: 16] & MASK, 16'h0} : 32'h0;
    end

    // Combine the per-channel views and cut out the requested lanes.
    always_comb begin
        view = 32'h0;
        for (int i = 0; i < NCH; i++) view = view | ch_view[i];
        rdata = rd_en ? lane_extract(view, size, boff) : 32'h0;
    end
endmodule

// File: rtl/dma_regbank.sv
// Top of the DMA register bank: decodes the bus request, steers writes to
// one channel's storage and returns masked read data combinationally.
// Assumes bus inputs are stable around the rising edge.
module dma_regbank
    import dma_regbank_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int AW      = 8,
    parameter int BASE    = 'hB0,
    parameter int STRIDE  = 12,
    parameter int FULL_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH*32-1:0] src_addr,
    output logic [NCH*32-1:0] dst_addr,
    output logic [NCH*16-1:0] xfer_count,
    output logic [NCH*16-1:0] ctrl_word,
    output logic [NCH-1:0]    enable_rise
);
    logic [NCH-1:0] hit;
    logic [1:0]     word_sel, boff;
    logic           legal, rd_en;

    dma_addr_decode #(.NCH(NCH), .AW(AW), .BASE(BASE), .STRIDE(STRIDE)) u_dec (
        .addr(bus_addr), .hit(hit), .word_sel(word_sel), .boff(boff)
    );

    // Request qualification shared by the write and read paths.
    assign legal = size_ok(bus_size, boff);
    assign rd_en = bus_valid && !bus_write && legal;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dma_chan_regs u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_hit(bus_valid && bus_write && legal && hit[i]),
            .word_sel(word_sel), .boff(boff), .size(bus_size), .wdata(bus_wdata),
            .src(src_addr[i*32 +: 32]), .dst(dst_addr[i*32 +: 32]),
            .count(xfer_count[i*16 +: 16]), .ctrl(ctrl_word[i*16 +: 16]),
            .enable_rise(enable_rise[i])
        );
    end

    dma_read_mux #(.NCH(NCH), .FULL_CH(FULL_CH)) u_rd (
        .rd_en(rd_en), .hit(hit), .word_sel(word_sel), .boff(boff), .size(bus_size),
        .ctrl_flat(ctrl_word), .rdata(bus_rdata)
    );

    // R7: address words of any channel always read zero.
    a_r7_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && word_sel != 2'd2) |-> bus_rdata == 32'h0);
    // R1: offsets outside every window read zero.
    a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && hit == '0) |-> bus_rdata == 32'h0);
    // R3: illegal size or misalignment reads zero.
    a_r3_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !legal) |-> bus_rdata == 32'h0);
    // R9: at most one channel can be armed per cycle.
    a_r9_single_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(enable_rise));
endmodule

// File: tb/dma_regbank_tb.sv
module dma_regbank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [127:0] src_addr, dst_addr;
    logic [63:0]  xfer_count, ctrl_word;
    logic [3:0]   enable_rise;

    dma_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_addr(src_addr), .dst_addr(dst_addr),
        .xfer_count(xfer_count), .ctrl_word(ctrl_word), .enable_rise(enable_rise)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state
    logic [31:0] m_src [4];
    logic [31:0] m_dst [4];
    logic [15:0] m_cnt [4];
    logic [15:0] m_ctl [4];
    logic [3:0]  m_rise;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_legal(input int sz, input int addr);
        if (sz == 3) return 0;
        if (sz == 2 && addr % 4 != 0) return 0;
        if (sz == 1 && addr % 2 != 0) return 0;
        return 1;
    endfunction

    function automatic logic [15:0] m_mask(input int ch);
        return (ch == 3) ? 16'hFFE0 : 16'hF7E0;
    endfunction

    function automatic logic [31:0] m_read(input int sz, input int addr);
        logic [31:0] r = 32'h0;
        int off = addr - 'hB0;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        if (!m_legal(sz, addr) || off < 0 || off >= 48) return 32'h0;
        for (int k = 0; k < n; k++) begin
            int ch = off / 12;
            int rb = off % 12 + k;
            logic [15:0] v = m_ctl[ch] & m_mask(ch);
            if (rb >= 10) r[8*k +: 8] = v[8*(rb-10) +: 8];
        end
        return r;
    endfunction

    task automatic m_write(input int sz, input int addr, input logic [31:0] wd);
        int off = addr - 'hB0;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        m_rise = 4'h0;
        if (!m_legal(sz, addr) || off < 0 || off >= 48) return;
        begin
            int ch = off / 12;
            bit old_en = m_ctl[ch][15];
            for (int k = 0; k < n; k++) begin
                int rb = off % 12 + k;
                if (rb < 4)       m_src[ch][8*rb +: 8]      = wd[8*k +: 8];
                else if (rb < 8)  m_dst[ch][8*(rb-4) +: 8]  = wd[8*k +: 8];
                else if (rb < 10) m_cnt[ch][8*(rb-8) +: 8]  = wd[8*k +: 8];
                else              m_ctl[ch][8*(rb-10) +: 8] = wd[8*k +: 8];
            end
            m_src[ch] &= 32'h0FFF_FFFE;
            m_dst[ch] &= 32'h0FFF_FFFE;
            if (!old_en && m_ctl[ch][15]) m_rise[ch] = 1'b1;
        end
    endtask

    task automatic cmp_state(input string tag);
        for (int c = 0; c < 4; c++) begin
            chk(tag, $sformatf("src%0d", c), src_addr[c*32 +: 32], m_src[c]);
            chk(tag, $sformatf("dst%0d", c), dst_addr[c*32 +: 32], m_dst[c]);
            chk(tag, $sformatf("cnt%0d", c), {16'h0, xfer_count[c*16 +: 16]}, {16'h0, m_cnt[c]});
            chk(tag, $sformatf("ctl%0d", c), {16'h0, ctrl_word[c*16 +: 16]}, {16'h0, m_ctl[c]});
        end
        chk(tag, "enable_rise", {28'h0, enable_rise}, {28'h0, m_rise});
    endtask

    // One bus cycle: drive at the falling edge, check read data, then state after the edge.
    task automatic access(input string tag, input bit v, input bit w, input int sz, input int addr, input logic [31:0] wd);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_size = 2'(sz); bus_addr = 8'(addr); bus_wdata = wd;
        #1;
        chk(tag, "rdata", bus_rdata, (v && !w) ? m_read(sz, addr) : 32'h0);
        @(posedge clk);
        #1;
        if (v && w) m_write(sz, addr, wd); else m_rise = 4'h0;
        cmp_state(tag);
    endtask

    task automatic wr(input string tag, input int sz, input int addr, input logic [31:0] wd);
        access(tag, 1, 1, sz, addr, wd);
    endtask

    task automatic rd(input string tag, input int sz, input int addr);
        access(tag, 1, 0, sz, addr, 32'hDEAD_BEEF);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        for (int c = 0; c < 4; c++) begin
            m_src[c] = 0; m_dst[c] = 0; m_cnt[c] = 0; m_ctl[c] = 0;
        end
        m_rise = 0;
        repeat (3) @(posedge clk);
        #1;
        cmp_state("R10");
        @(negedge clk);
        rst_n = 1'b1;

        // R4: masking of addresses
        wr("R4", 2, 'hB0, 32'hFFFF_FFFF);
        wr("R4", 2, 'hC0, 32'h1234_5679);
        // R7: write-only locations read zero
        rd("R7", 2, 'hB0); rd("R7", 1, 'hB2); rd("R7", 0, 'hB1);
        rd("R7", 2, 'hC0); wr("R7", 1, 'hB8, 32'h0000_ABCD); rd("R7", 1, 'hB8); rd("R7", 0, 'hB9);
        // R5: narrow writes merge
        wr("R5", 2, 'hC8, 32'h0111_2220);
        wr("R5", 0, 'hC9, 32'h0000_00AB);
        wr("R5", 1, 'hDA, 32'h0000_0345);
        wr("R5", 0, 'hDC, 32'h0000_0077);
        // R6 and R9: word at +8 loads count and control, arms channel 1
        wr("R6", 2, 'hC4, 32'h8000_1234);
        wr("R9", 2, 'hC4, 32'h8000_5678);
        wr("R9", 1, 'hC6, 32'h0000_0000);
        wr("R9", 0, 'hC7, 32'h0000_0080);
        access("R11", 0, 0, 0, 0, 0);
        // R8: channel-dependent readback mask
        wr("R8", 1, 'hBA, 32'h0000_FFFF);
        wr("R8", 1, 'hDE, 32'h0000_FFFF);
        rd("R8", 1, 'hBA); rd("R8", 1, 'hDE); rd("R8", 2, 'hDC); rd("R8", 2, 'hB8);
        // R2: byte read of the high control byte, upper bits zero
        rd("R2", 0, 'hBB); rd("R2", 0, 'hDF); rd("R2", 0, 'hBA);
        // R3: illegal size and misalignment
        wr("R3", 2, 'hB2, 32'h0000_0000);
        wr("R3", 1, 'hB5, 32'hFFFF_FFFF);
        wr("R3", 3, 'hB0, 32'h0000_0000);
        rd("R3", 3, 'hBA); rd("R3", 1, 'hBB); rd("R3", 2, 'hBA);
        // R1: outside the window
        wr("R1", 2, 'hAC, 32'hFFFF_FFFF);
        wr("R1", 2, 'hE0, 32'hFFFF_FFFF);
        rd("R1", 1, 'hAE); rd("R1", 2, 'hE0);
        // R5: random mix checked every cycle
        for (int n = 0; n < 600; n++) begin
            int a = 'hA8 + int'($urandom_range(0, 59));
            access("R5", 1, $urandom_range(0, 1) == 1, int'($urandom_range(0, 3)), a, $urandom);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule